// File: doc/BRIEF.md
# Indirect-Access SCSI Controller Register Port

This block is the host-facing register window of a small SCSI bus controller model. The host sees only two byte locations. A write to the select location picks one register of a byte-wide register file. Reads and writes at the value location then reach that register. Each value write stores the byte and moves the select pointer on by one, so a run of neighbouring registers can be loaded without reselecting.

A command engine watches writes to the command register. It handles a controller reset, a selection with attention, and an information transfer. The transfer consumes data-register writes against a 24-bit byte count. The engine reports each outcome through the status register and a pending-interrupt flag, and the interrupt output is a registered copy of that flag. Two inputs stand in for the SCSI bus. One is a per-ID target-present vector. The other is a direction flag that says whether the target wants data sent out.

Top module: `scsi_regport`

## Requirements
- R1: A write at byte offset 3 loads the select pointer with the low 5 bits of the byte. A write at offset 7 stores the byte in the selected register and increments the pointer, which wraps from 31 to 0.
- R2: A read at offset 7 returns the selected register on host_rdata one clock after the read strobe, and it does not move the pointer.
- R3: A read at offset 3 returns auxiliary status. Bit 0 is always 1, bit 7 is the pending-interrupt flag, and the other bits are 0.
- R4: irq equals the pending flag delayed by one clock.
- R5: A value-port read while the status register (index 0x17) is selected clears the pending flag.
- R6: A write to the control register (index 0x01) with bit 3 set clears the pending flag. A control write with bit 3 clear leaves the flag unchanged.
- R7: The command register is at index 0x18. Its bits 6:0 are the command code, and bit 7 is ignored when the code is decoded.
- R8: Command 0x00 (reset) writes 0x01 to status and sets the pending flag.
- R9: Command 0x06 (select with attention) sets the pending flag. The target ID is bits 2:0 of the destination register (index 0x15). If target_present has that ID's bit set, status becomes 0x8A. Otherwise status becomes 0x42.
- R10: Command 0x20 (transfer) loads a 24-bit count from the count registers 0x12:0x13:0x14 (high:middle:low). It zeroes the byte pointer and clears the pending flag. Each later write to the data register (index 0x19) consumes one byte. The write that reaches the count sets the pending flag and writes status 0x18 if target_wants_out is 1, or 0x19 if it is 0.
- R11: A data-register write when no transfer is active, or after the count has been reached, changes neither status nor the pending flag, and it sets data_err. data_err stays set until reset.
- R12: Synchronous reset clears every register, the select pointer, the pending flag, irq and data_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 3 | Host byte offset; 3 is the select/aux port, 7 is the value port |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Registered read byte |
| target_present | input | 8 | One bit per SCSI ID, set when a target answers selection |
| target_wants_out | input | 1 | Target asks for data-out at the end of a transfer |
| irq | output | 1 | Registered interrupt request |
| data_err | output | 1 | Sticky flag for a data write outside a transfer |

## Verification
The bench builds the block with its default parameters: 32 registers, eight target IDs, and ports at offsets 3 and 7. With 32 registers, the pointer mask (0x26 selects 6) and the wrap from 31 to 0 each take only a couple of writes to reach. Eight IDs are enough to show both the present-target and absent-target outcomes of a selection. A transfer of 258 bytes runs the count's middle byte, and the bench checks that completion fires on the last byte and not on the byte before it.

// File: rtl/scsi_regport_pkg.sv
package scsi_regport_pkg;
  localparam int unsigned DATA_W = 8;

  // register indices (the count registers and destination are consecutive
  // so that auto-increment loads them in one run)
  localparam int unsigned IDX_CTRL   = 'h01;
  localparam int unsigned IDX_CNT_HI = 'h12;
  localparam int unsigned IDX_CNT_MD = 'h13;
  localparam int unsigned IDX_CNT_LO = 'h14;
  localparam int unsigned IDX_DEST   = 'h15;
  localparam int unsigned IDX_STATUS = 'h17;
  localparam int unsigned IDX_CMD    = 'h18;
  localparam int unsigned IDX_DATA   = 'h19;

  localparam int unsigned CTRL_CLR_BIT = 3;
  localparam int unsigned AUX_RDY_BIT  = 0;
  localparam int unsigned AUX_INT_BIT  = 7;

  typedef enum logic [6:0] {
    CMD_RESET   = 7'h00,
    CMD_SEL_ATN = 7'h06,
    CMD_XFER    = 7'h20
  } cmd_code_e;

  typedef enum logic [1:0] {
    PH_DATA_OUT = 2'd0,
    PH_DATA_IN  = 2'd1,
    PH_COMMAND  = 2'd2
  } bus_phase_e;

  localparam logic [7:0] ST_RESET_DONE  = 8'h01;
  localparam logic [7:0] ST_SEL_TIMEOUT = 8'h42;
  localparam logic [7:0] ST_SELECTED    = 8'h88;
  localparam logic [7:0] ST_XFER_DONE   = 8'h18;
endpackage

// File: rtl/scsi_regport_ptr.sv
module scsi_regport_ptr #(
  parameter int unsigned SEL_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [SEL_W-1:0] load_val,
  input  logic             step,
  output logic [SEL_W-1:0] sel
);
  always_ff @(posedge clk) begin
    if (rst)       sel <= '0;
    else if (load) sel <= load_val;
    else if (step) sel <= sel + SEL_W'(1);
  end
endmodule

// File: rtl/scsi_regport_file.sv
module scsi_regport_file #(
  parameter int unsigned NREGS  = 32,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned SEL_W = $clog2(NREGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_we,
  input  logic [SEL_W-1:0]  host_idx,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              eng_we,
  input  logic [SEL_W-1:0]  eng_idx,
  input  logic [DATA_W-1:0] eng_wdata,
  output logic [DATA_W-1:0] regs [NREGS]
);
  for (genvar i = 0; i < NREGS; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)
        regs[i] <= '0;
      else if (eng_we && eng_idx == SEL_W'(i))
        regs[i] <= eng_wdata;
      else if (host_we && host_idx == SEL_W'(i))
        regs[i] <= host_wdata;
    end
  end
endmodule

// File: rtl/scsi_regport_engine.sv
module scsi_regport_engine
  import scsi_regport_pkg::*;
#(
  parameter int unsigned SEL_W = 5,
  parameter int unsigned NTGT  = 8,
  localparam int unsigned TID_W = $clog2(NTGT),
  localparam int unsigned CNT_W = 3 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              val_wr,
  input  logic              val_rd,
  input  logic [SEL_W-1:0]  sel,
  input  logic [6:0]        cmd_code,
  input  logic              ctrl_clr,
  input  logic [DATA_W-1:0] cnt_hi,
  input  logic [DATA_W-1:0] cnt_md,
  input  logic [DATA_W-1:0] cnt_lo,
  input  logic [TID_W-1:0]  tgt_id,
  input  logic [NTGT-1:0]   target_present,
  input  logic              target_wants_out,
  output logic              pending,
  output logic              st_we,
  output logic [DATA_W-1:0] st_val,
  output logic              data_err
);
  logic             active;
  logic [CNT_W-1:0] xfer_len;
  logic [CNT_W-1:0] byte_ptr;

  logic cmd_wr, data_wr, ctrl_wr, stat_rd, accept, last;
  bus_phase_e end_phase;

  always_comb begin
    cmd_wr  = val_wr && sel == SEL_W'(IDX_CMD);
    data_wr = val_wr && sel == SEL_W'(IDX_DATA);
    ctrl_wr = val_wr && sel == SEL_W'(IDX_CTRL);
    stat_rd = val_rd && sel == SEL_W'(IDX_STATUS);
    accept  = data_wr && active && (byte_ptr < xfer_len);
    last    = accept && (byte_ptr + CNT_W'(1) == xfer_len);
    end_phase = target_wants_out ? PH_DATA_OUT : PH_DATA_IN;
  end

  always_comb begin
    st_we  = 1'b0;
    st_val = '0;
    if (cmd_wr && cmd_code == CMD_RESET) begin
      st_we  = 1'b1;
      st_val = ST_RESET_DONE;
    end else if (cmd_wr && cmd_code == CMD_SEL_ATN) begin
      st_we  = 1'b1;
      st_val = target_present[tgt_id] ? (ST_SELECTED | DATA_W'(PH_COMMAND))
                                      : ST_SEL_TIMEOUT;
    end else if (last) begin
      st_we  = 1'b1;
      st_val = ST_XFER_DONE | DATA_W'(end_phase);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pending  <= 1'b0;
      active   <= 1'b0;
      xfer_len <= '0;
      byte_ptr <= '0;
      data_err <= 1'b0;
    end else begin
      if (cmd_wr) begin
        unique case (cmd_code)
          CMD_RESET, CMD_SEL_ATN: begin
            pending <= 1'b1;
            active  <= 1'b0;
          end
          CMD_XFER: begin
            xfer_len <= {cnt_hi, cnt_md, cnt_lo};
            byte_ptr <= '0;
            active   <= 1'b1;
            pending  <= 1'b0;
          end
          default: ;
        endcase
      end
      if (accept) begin
        byte_ptr <= byte_ptr + CNT_W'(1);
        if (last) begin
          active  <= 1'b0;
          pending <= 1'b1;
        end
      end
      if (data_wr && !accept) data_err <= 1'b1;
      if (ctrl_wr && ctrl_clr) pending <= 1'b0;
      if (stat_rd) pending <= 1'b0;
    end
  end
endmodule

// File: rtl/scsi_regport.sv
module scsi_regport
  import scsi_regport_pkg::*;
#(
  parameter int unsigned NREGS    = 32,
  parameter int unsigned NTGT     = 8,
  parameter int unsigned ADDR_W   = 3,
  parameter int unsigned SEL_OFS  = 3,
  parameter int unsigned VAL_OFS  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [7:0]        host_wdata,
  output logic [7:0]        host_rdata,
  input  logic [NTGT-1:0]   target_present,
  input  logic              target_wants_out,
  output logic              irq,
  output logic              data_err
);
  localparam int unsigned SEL_W = $clog2(NREGS);
  localparam int unsigned TID_W = $clog2(NTGT);

  logic is_sel_port, is_val_port;
  logic addr_wr, val_wr, addr_rd, val_rd;
  logic [SEL_W-1:0]  sel;
  logic [DATA_W-1:0] regs [NREGS];
  logic              pending, st_we;
  logic [DATA_W-1:0] st_val;

  always_comb begin
    is_sel_port = host_addr == ADDR_W'(SEL_OFS);
    is_val_port = host_addr == ADDR_W'(VAL_OFS);
    addr_wr = host_wr && is_sel_port;
    val_wr  = host_wr && is_val_port;
    addr_rd = host_rd && !host_wr && is_sel_port;
    val_rd  = host_rd && !host_wr && is_val_port;
  end

  scsi_regport_ptr #(.SEL_W(SEL_W)) u_ptr (
    .clk(clk), .rst(rst),
    .load(addr_wr), .load_val(host_wdata[SEL_W-1:0]),
    .step(val_wr), .sel(sel)
  );

  scsi_regport_file #(.NREGS(NREGS), .DATA_W(DATA_W)) u_file (
    .clk(clk), .rst(rst),
    .host_we(val_wr), .host_idx(sel), .host_wdata(host_wdata),
    .eng_we(st_we), .eng_idx(SEL_W'(IDX_STATUS)), .eng_wdata(st_val),
    .regs(regs)
  );

  scsi_regport_engine #(.SEL_W(SEL_W), .NTGT(NTGT)) u_eng (
    .clk(clk), .rst(rst),
    .val_wr(val_wr), .val_rd(val_rd), .sel(sel),
    .cmd_code(host_wdata[6:0]), .ctrl_clr(host_wdata[CTRL_CLR_BIT]),
    .cnt_hi(regs[IDX_CNT_HI]), .cnt_md(regs[IDX_CNT_MD]),
    .cnt_lo(regs[IDX_CNT_LO]), .tgt_id(regs[IDX_DEST][TID_W-1:0]),
    .target_present(target_present), .target_wants_out(target_wants_out),
    .pending(pending), .st_we(st_we), .st_val(st_val), .data_err(data_err)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      host_rdata <= '0;
      irq        <= 1'b0;
    end else begin
      irq <= pending;
      if (addr_rd) begin
        host_rdata <= '0;
        host_rdata[AUX_RDY_BIT] <= 1'b1;
        host_rdata[AUX_INT_BIT] <= pending;
      end else if (val_rd) begin
        host_rdata <= regs[sel];
      end
    end
  end
endmodule

// File: rtl/scsi_regport_chk.sv
module scsi_regport_chk
  import scsi_regport_pkg::*;
#(
  parameter int unsigned SEL_W   = 5,
  parameter int unsigned ADDR_W  = 3,
  parameter int unsigned SEL_OFS = 3,
  parameter int unsigned VAL_OFS = 7
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] host_addr,
  input logic              host_wr,
  input logic              host_rd,
  input logic [SEL_W-1:0]  wsel,
  input logic              rdy_bit,
  input logic              irq,
  input logic              data_err,
  input logic              pending,
  input logic [SEL_W-1:0]  sel
);
  // R1: select write loads the pointer
  p_ptr_load_r1: assert property (@(posedge clk) disable iff (rst)
    host_wr && host_addr == ADDR_W'(SEL_OFS) |=> sel == $past(wsel));
  // R1: value write steps the pointer
  p_ptr_step_r1: assert property (@(posedge clk) disable iff (rst)
    host_wr && host_addr == ADDR_W'(VAL_OFS) |=> sel == $past(sel) + SEL_W'(1));
  // R2: value read leaves the pointer
  p_rd_hold_r2: assert property (@(posedge clk) disable iff (rst)
    host_rd && !host_wr && host_addr == ADDR_W'(VAL_OFS) |=> $stable(sel));
  // R3: aux read always shows the ready bit
  p_aux_rdy_r3: assert property (@(posedge clk) disable iff (rst)
    host_rd && !host_wr && host_addr == ADDR_W'(SEL_OFS) |=> rdy_bit);
  // R4: irq follows the pending flag by one clock
  p_irq_lag_r4: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> irq == $past(pending));
  // R5: status read clears pending
  p_stat_clr_r5: assert property (@(posedge clk) disable iff (rst)
    host_rd && !host_wr && host_addr == ADDR_W'(VAL_OFS) &&
    sel == SEL_W'(IDX_STATUS) |=> !pending);
  // R11: error flag is sticky
  p_err_sticky_r11: assert property (@(posedge clk) disable iff (rst)
    data_err |=> data_err);
endmodule

bind scsi_regport scsi_regport_chk #(
  .SEL_W(SEL_W), .ADDR_W(ADDR_W), .SEL_OFS(SEL_OFS), .VAL_OFS(VAL_OFS)
) u_chk (
  .clk(clk), .rst(rst), .host_addr(host_addr), .host_wr(host_wr),
  .host_rd(host_rd), .wsel(host_wdata[SEL_W-1:0]), .rdy_bit(host_rdata[0]),
  .irq(irq), .data_err(data_err), .pending(pending), .sel(sel)
);

// File: tb/scsi_regport_tb.sv
module scsi_regport_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] host_addr = '0;
  logic       host_wr = 1'b0, host_rd = 1'b0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic [7:0] target_present = '0;
  logic       target_wants_out = 1'b0;
  logic       irq, data_err;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  scsi_regport u_dut (
    .clk(clk), .rst(rst), .host_addr(host_addr), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .target_present(target_present), .target_wants_out(target_wants_out),
    .irq(irq), .data_err(data_err)
  );

  // {is_read, addr, data, check, expected}
  localparam logic [20:0] VEC [16] = '{
    {1'b0, 3'd3, 8'h05, 1'b0, 8'h00},
    {1'b0, 3'd7, 8'hA1, 1'b0, 8'h00},
    {1'b0, 3'd7, 8'hB2, 1'b0, 8'h00},
    {1'b0, 3'd3, 8'h05, 1'b0, 8'h00},
    {1'b1, 3'd7, 8'h00, 1'b1, 8'hA1},
    {1'b1, 3'd7, 8'h00, 1'b1, 8'hA1},
    {1'b0, 3'd3, 8'h26, 1'b0, 8'h00},
    {1'b1, 3'd7, 8'h00, 1'b1, 8'hB2},
    {1'b0, 3'd3, 8'h1F, 1'b0, 8'h00},
    {1'b0, 3'd7, 8'h3C, 1'b0, 8'h00},
    {1'b0, 3'd7, 8'h4D, 1'b0, 8'h00},
    {1'b0, 3'd3, 8'h00, 1'b0, 8'h00},
    {1'b1, 3'd7, 8'h00, 1'b1, 8'h4D},
    {1'b0, 3'd3, 8'h1F, 1'b0, 8'h00},
    {1'b1, 3'd7, 8'h00, 1'b1, 8'h3C},
    {1'b1, 3'd3, 8'h00, 1'b1, 8'h01}
  };

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] q);
    @(negedge clk);
    host_addr = a; host_rd = 1'b1;
    @(negedge clk);
    host_rd = 1'b0;
    q = host_rdata;
  endtask

  task automatic setreg(logic [7:0] idx, logic [7:0] v);
    wr(3'd3, idx); wr(3'd7, v);
  endtask

  task automatic getreg(logic [7:0] idx, output logic [7:0] q);
    wr(3'd3, idx); rd(3'd7, q);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] q;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R12: reset state
    rd(3'd3, q); check("R12 aux after reset", q, 8'h01);
    check("R12 irq after reset", {7'd0, irq}, 8'h00);
    check("R12 err after reset", {7'd0, data_err}, 8'h00);

    // R1 R2 R3: table walk
    foreach (VEC[i]) begin
      if (VEC[i][20]) rd(VEC[i][19:17], q);
      else            wr(VEC[i][19:17], VEC[i][16:9]);
      if (VEC[i][8]) check("R1/R2/R3 table", q, VEC[i][7:0]);
    end

    // R8 R7: reset command with bit 7 set
    setreg(8'h18, 8'h80);
    check("R4 irq lags pending", {7'd0, irq}, 8'h00);
    @(negedge clk);
    check("R4 irq raised", {7'd0, irq}, 8'h01);
    rd(3'd3, q); check("R8 aux int", q, 8'h81);
    getreg(8'h17, q); check("R8 R7 reset status", q, 8'h01);
    rd(3'd3, q); check("R5 status read clears", q, 8'h01);
    @(negedge clk);
    check("R5 irq dropped", {7'd0, irq}, 8'h00);

    // R6: control clear bit
    setreg(8'h18, 8'h00);
    setreg(8'h01, 8'h04);
    rd(3'd3, q); check("R6 ctrl without bit3 keeps", q, 8'h81);
    setreg(8'h01, 8'h08);
    rd(3'd3, q); check("R6 ctrl bit3 clears", q, 8'h01);

    // R9: selection, absent then present
    target_present = 8'b0000_0100;
    setreg(8'h15, 8'h03);
    setreg(8'h18, 8'h86);
    rd(3'd3, q); check("R9 sel pending", q, 8'h81);
    getreg(8'h17, q); check("R9 absent timeout", q, 8'h42);
    target_present = 8'b0000_1000;
    setreg(8'h18, 8'h06);
    getreg(8'h17, q); check("R9 present selected", q, 8'h8A);

    // R10: transfer of 3 bytes, data-in
    setreg(8'h18, 8'h00);   // leave pending set before transfer
    wr(3'd3, 8'h12); wr(3'd7, 8'h00); wr(3'd7, 8'h00); wr(3'd7, 8'h03);
    setreg(8'h18, 8'h20);
    rd(3'd3, q); check("R10 xfer clears pending", q, 8'h01);
    setreg(8'h19, 8'h11); setreg(8'h19, 8'h22);
    rd(3'd3, q); check("R10 not done early", q, 8'h01);
    setreg(8'h19, 8'h33);
    rd(3'd3, q); check("R10 done pending", q, 8'h81);
    getreg(8'h17, q); check("R10 data-in status", q, 8'h19);
    check("R10 no err", {7'd0, data_err}, 8'h00);

    // R11: write beyond count
    setreg(8'h19, 8'h44);
    rd(3'd3, q); check("R11 beyond count no int", q, 8'h01);
    getreg(8'h17, q); check("R11 status kept", q, 8'h19);
    check("R11 err set", {7'd0, data_err}, 8'h01);

    // R10: 258-byte transfer, data-out
    target_wants_out = 1'b1;
    wr(3'd3, 8'h12); wr(3'd7, 8'h00); wr(3'd7, 8'h01); wr(3'd7, 8'h02);
    setreg(8'h18, 8'h20);
    for (int n = 0; n < 257; n++) setreg(8'h19, 8'(n));
    rd(3'd3, q); check("R10 257 of 258 pending", q, 8'h01);
    setreg(8'h19, 8'hFF);
    rd(3'd3, q); check("R10 258 done", q, 8'h81);
    getreg(8'h17, q); check("R10 data-out status", q, 8'h18);

    // R12: synchronous reset clears everything
    do_reset();
    check("R12 err cleared", {7'd0, data_err}, 8'h00);
    check("R12 irq cleared", {7'd0, irq}, 8'h00);
    getreg(8'h17, q); check("R12 status cleared", q, 8'h00);
    getreg(8'h05, q); check("R12 reg cleared", q, 8'h00);

    // R11: data write with no transfer active
    setreg(8'h19, 8'h55);
    rd(3'd3, q); check("R11 idle write no int", q, 8'h01);
    getreg(8'h17, q); check("R11 idle status kept", q, 8'h00);
    check("R11 idle err", {7'd0, data_err}, 8'h01);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule